// File: doc/BRIEF.md
# Delay Code Search Encoder

This block turns a wanted delay, given in nanoseconds, plus the frequency of the clock that will time it, into a pair of small codes. The codes select an odd prescale multiplier and a power-of-two scale multiplier. Their product is the delay in clock cycles. The encoder returns the pair whose product is the smallest one that still covers the wanted delay. If no pair is long enough, it returns the longest pair and raises a saturation flag.

The work runs serially after a start strobe, which latches both inputs. First, a bit-serial restoring divider turns the product of the delay and the frequency into a whole cycle count, rounded up. Then a scan walks the code space one candidate per clock. The codes and the saturation flag are written together with a one-cycle done pulse. They hold their values until the next result.

Top module: `dly_scale_enc`

## Requirements
- R1: In reset and afterwards, until the first result, `done` and `sat` are 0, and `psc_code` and `scl_code` are 0.
- R2: The cycle count needed is ceil(dly_ns × rate_hz / 1,000,000,000). A nonzero remainder raises the count by one, so 7 ns at 300 MHz needs 3 cycles, not 2.
- R3: Prescale code p (2 bits, 0..3) selects the multiplier 2p+1, which is one of 1, 3, 5 or 7. Scale code s (4 bits, 0..15) selects the multiplier 2^(s+1). The delay of the pair is the product of the two multipliers.
- R4: The result is the pair whose product is the smallest one that is greater than or equal to the needed count. An exact match is accepted. When two pairs tie, the lower prescale code wins.
- R5: A needed count of 0 gives prescale code 0, scale code 0 and `sat` = 0. The product of that pair is 2.
- R6: If the needed count exceeds 458752 (7 × 2^16), the result is prescale code 3, scale code 15 and `sat` = 1. Otherwise `sat` is 0.
- R7: `done` is high for exactly one clock cycle per accepted start, in the same cycle that the new codes and `sat` first appear. The outputs then keep their values until the next `done`.
- R8: `dly_ns` and `rate_hz` are captured on the cycle in which `start` is accepted. A `start` that arrives while a calculation is running is ignored: it changes neither the result nor the number of `done` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calculation (accepted only when idle) |
| dly_ns | input | 32 | Wanted delay in nanoseconds |
| rate_hz | input | 32 | Timing clock frequency in Hz |
| done | output | 1 | One-cycle pulse: result valid |
| sat | output | 1 | No pair covered the needed count |
| psc_code | output | 2 | Selected prescale code |
| scl_code | output | 4 | Selected scale code |

## Verification
The assertions check the following on every cycle:
- the divider's quotient and remainder rebuild the latched product exactly, and the remainder stays below the divisor;
- any pair reported without saturation covers the needed count;
- the next smaller scale code of that prescaler would not cover it;
- saturation always comes with the maximum codes;
- `done` is a single-cycle pulse, and the outputs only change with it;
- the latched operands do not change when `start` comes during a calculation.

Only the bench's scenarios show the rest:
- that the rounding up happens in the right cases;
- that the choice across the different prescalers is the true minimum;
- the exact-fit boundary and the first count past it;
- a zero request;
- that a start arriving mid-run yields neither a second pulse nor a different result.

// File: rtl/dly_enc_pkg.sv
`timescale 1ns/1ps
package dly_enc_pkg;

    localparam int PSC_W    = 2;
    localparam int SCL_W    = 4;
    // widest candidate: 7 << 16
    localparam int CAND_W   = PSC_W + 1 + (1 << SCL_W);
    localparam int NS_DIV_W = 30;
    localparam logic [NS_DIV_W-1:0] NS_PER_S = 30'd1000000000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIV,
        ST_SRCH
    } enc_state_t;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [SCL_W-1:0] scl;
    } code_pair_t;

    // cycles produced by a code pair: (2p+1) * 2^(s+1)
    function automatic logic [CAND_W-1:0] cand_value(code_pair_t c);
        logic [CAND_W-1:0] base;
        base = CAND_W'({c.psc, 1'b1});
        return base << ({1'b0, c.scl} + 5'd1);
    endfunction

endpackage

// File: rtl/dly_div.sv
`timescale 1ns/1ps
module dly_div #(
    parameter int NUM_W = 64,
    parameter int DEN_W = 30,
    parameter logic [DEN_W-1:0] DEN = 30'd1000000000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    output logic [NUM_W-1:0] quo,
    output logic             rem_nz,
    output logic             fin
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] shreg;
    logic [DEN_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;
    logic [NUM_W-1:0] num_keep;

    always_comb begin
        trial = {rem_q, shreg[NUM_W-1]};
        fits  = trial >= {1'b0, DEN};
        diff  = fits ? (trial - {1'b0, DEN}) : trial;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            rem_q    <= '0;
            cnt      <= '0;
            busy     <= 1'b0;
            fin      <= 1'b0;
            num_keep <= '0;
        end else begin
            fin <= 1'b0;
            if (go && !busy) begin
                shreg    <= num;
                num_keep <= num;
                rem_q    <= '0;
                cnt      <= CNT_W'(NUM_W);
                busy     <= 1'b1;
            end else if (busy) begin
                shreg <= {shreg[NUM_W-2:0], fits};
                rem_q <= diff[DEN_W-1:0];
                cnt   <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end

    assign quo    = shreg;
    assign rem_nz = |rem_q;

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (rst)
        fin |-> ((2*NUM_W)'(shreg) * (2*NUM_W)'(DEN) + (2*NUM_W)'(rem_q))
                == (2*NUM_W)'(num_keep)); // R2
    AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
        rem_q < DEN); // R2

endmodule

// File: rtl/dly_search.sv
`timescale 1ns/1ps
module dly_search
    import dly_enc_pkg::*;
#(
    parameter int NEED_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [NEED_W-1:0] need,
    output code_pair_t        res,
    output logic              sat,
    output logic              fin
);
    logic              busy;
    logic [NEED_W-1:0] need_q;
    code_pair_t        cur;
    code_pair_t        best;
    logic [CAND_W-1:0] best_val;
    logic              found;

    logic [CAND_W-1:0] cv;
    logic              hit, take, found_n, adv, last_psc, last_scl;
    code_pair_t        best_n;
    logic [CAND_W-1:0] bval_n;

    always_comb begin
        cv       = cand_value(cur);
        hit      = need_q <= NEED_W'(cv);
        take     = busy && hit && (!found || cv < best_val);
        found_n  = found | take;
        best_n   = take ? cur : best;
        bval_n   = take ? cv : best_val;
        last_scl = cur.scl == '1;
        last_psc = cur.psc == '1;
        adv      = hit || last_scl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            need_q   <= '0;
            cur      <= '0;
            best     <= '0;
            best_val <= '0;
            found    <= 1'b0;
            res      <= '0;
            sat      <= 1'b0;
            fin      <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go && !busy) begin
                busy     <= 1'b1;
                need_q   <= need;
                cur      <= '0;
                best     <= '0;
                best_val <= '0;
                found    <= 1'b0;
            end else if (busy) begin
                found    <= found_n;
                best     <= best_n;
                best_val <= bval_n;
                if (adv) begin
                    if (last_psc) begin
                        busy <= 1'b0;
                        fin  <= 1'b1;
                        sat  <= !found_n;
                        res  <= found_n ? best_n : '1;
                    end else begin
                        cur.psc <= cur.psc + 1'b1;
                        cur.scl <= '0;
                    end
                end else begin
                    cur.scl <= cur.scl + 1'b1;
                end
            end
        end
    end

    AST_BEST_COVERS: assert property (@(posedge clk) disable iff (rst)
        found |-> need_q <= NEED_W'(best_val)); // R4
    AST_FIN_PULSE: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin); // R7

endmodule

// File: rtl/dly_scale_enc.sv
`timescale 1ns/1ps
module dly_scale_enc
    import dly_enc_pkg::*;
#(
    parameter int DLY_W  = 32,
    parameter int RATE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DLY_W-1:0]  dly_ns,
    input  logic [RATE_W-1:0] rate_hz,
    output logic              done,
    output logic              sat,
    output logic [PSC_W-1:0]  psc_code,
    output logic [SCL_W-1:0]  scl_code
);
    localparam int PROD_W = DLY_W + RATE_W;

    enc_state_t        state;
    logic [DLY_W-1:0]  dly_q;
    logic [RATE_W-1:0] rate_q;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] need_q;
    logic              div_go, srch_go;
    logic [PROD_W-1:0] quo;
    logic              rem_nz, div_fin;
    code_pair_t        s_res;
    logic              s_sat, s_fin;

    assign prod = PROD_W'(dly_q) * PROD_W'(rate_q);

    dly_div #(
        .NUM_W (PROD_W),
        .DEN_W (NS_DIV_W),
        .DEN   (NS_PER_S)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .go     (div_go),
        .num    (prod),
        .quo    (quo),
        .rem_nz (rem_nz),
        .fin    (div_fin)
    );

    dly_search #(
        .NEED_W (PROD_W)
    ) u_srch (
        .clk  (clk),
        .rst  (rst),
        .go   (srch_go),
        .need (need_q),
        .res  (s_res),
        .sat  (s_sat),
        .fin  (s_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            dly_q    <= '0;
            rate_q   <= '0;
            need_q   <= '0;
            div_go   <= 1'b0;
            srch_go  <= 1'b0;
            done     <= 1'b0;
            sat      <= 1'b0;
            psc_code <= '0;
            scl_code <= '0;
        end else begin
            done    <= 1'b0;
            div_go  <= 1'b0;
            srch_go <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    dly_q  <= dly_ns;
                    rate_q <= rate_hz;
                    div_go <= 1'b1;
                    state  <= ST_DIV;
                end
                ST_DIV: if (div_fin) begin
                    need_q  <= quo + PROD_W'(rem_nz);
                    srch_go <= 1'b1;
                    state   <= ST_SRCH;
                end
                ST_SRCH: if (s_fin) begin
                    psc_code <= s_res.psc;
                    scl_code <= s_res.scl;
                    sat      <= s_sat;
                    done     <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(psc_code) && $stable(scl_code) && $stable(sat))); // R7
    AST_SAT_CODES: assert property (@(posedge clk) disable iff (rst)
        sat |-> (psc_code == '1 && scl_code == '1)); // R6
    AST_RESULT_COVERS: assert property (@(posedge clk) disable iff (rst)
        (done && !sat) |-> need_q <= PROD_W'(cand_value('{psc: psc_code, scl: scl_code}))); // R4
    AST_RESULT_TIGHT: assert property (@(posedge clk) disable iff (rst)
        (done && !sat && scl_code != '0) |->
        PROD_W'(cand_value('{psc: psc_code, scl: scl_code - 1'b1})) < need_q); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && start) |=> ($stable(dly_q) && $stable(rate_q))); // R8

endmodule

// File: tb/dly_scale_enc_test.sv
`timescale 1ns/1ps
module dly_scale_enc_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] dly_ns = '0;
    logic [31:0] rate_hz = '0;
    logic        done, sat;
    logic [1:0]  psc_code;
    logic [3:0]  scl_code;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;

    always #2.5 clk = ~clk;

    dly_scale_enc uut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .dly_ns   (dly_ns),
        .rate_hz  (rate_hz),
        .done     (done),
        .sat      (sat),
        .psc_code (psc_code),
        .scl_code (scl_code)
    );

    always @(negedge clk) if (!rst && done) done_cnt++;

    typedef struct packed {
        logic [31:0] d;
        logic [31:0] h;
        logic [1:0]  p;
        logic [3:0]  s;
        logic        x;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'd50,   32'd100000000, 2'd1, 4'd0,  1'b0}, // need 5  -> 3*2   R4
        '{32'd50,   32'd60000000,  2'd0, 4'd1,  1'b0}, // need 3  -> 1*4   R3
        '{32'd1,    32'd1,         2'd0, 4'd0,  1'b0}, // need 1 (rounded up) R2
        '{32'd0,    32'd100000000, 2'd0, 4'd0,  1'b0}, // need 0  R5
        '{32'd1000, 32'd1000000000,2'd0, 4'd9,  1'b0}, // need 1000 -> 1024
        '{32'd100,  32'd1000000000,2'd3, 4'd3,  1'b0}, // need 100 -> 7*16
        '{32'd458752,32'd1000000000,2'd3,4'd15, 1'b0}, // exact max R6
        '{32'd458753,32'd1000000000,2'd3,4'd15, 1'b1}, // just past max R6
        '{32'd7,    32'd300000000, 2'd0, 4'd1,  1'b0}, // 2.1 -> 3 R2
        '{32'd6,    32'd1000000000,2'd1, 4'd0,  1'b0}, // exact 6
        '{32'd7,    32'd1000000000,2'd0, 4'd2,  1'b0}, // 7 -> 8
        '{32'hFFFFFFFF,32'hFFFFFFFF,2'd3,4'd15, 1'b1}, // huge R6
        '{32'd20,   32'd1000000000,2'd2, 4'd1,  1'b0}  // 20 -> 5*4
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        checks++;
        if (!done) begin
            errors++;
            $display("FAIL %s timeout actual=0 expected=1", tag);
        end
    endtask

    task automatic launch(input logic [31:0] d, input logic [31:0] h);
        @(negedge clk);
        dly_ns  = d;
        rate_hz = h;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 done", int'(done), 0);
        chk("R1 sat", int'(sat), 0);
        chk("R1 psc", int'(psc_code), 0);
        chk("R1 scl", int'(scl_code), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 done after release", int'(done), 0);

        // R2 R3 R4 R5 R6 table
        for (int i = 0; i < NV; i++) begin
            launch(VECS[i].d, VECS[i].h);
            wait_done($sformatf("R4 vec %0d", i));
            chk($sformatf("R4 vec %0d psc", i), int'(psc_code), int'(VECS[i].p));
            chk($sformatf("R4 vec %0d scl", i), int'(scl_code), int'(VECS[i].s));
            chk($sformatf("R6 vec %0d sat", i), int'(sat), int'(VECS[i].x));
            @(negedge clk);
            // R7: single-cycle pulse, result held
            chk($sformatf("R7 vec %0d pulse", i), int'(done), 0);
            chk($sformatf("R7 vec %0d hold", i), int'(psc_code), int'(VECS[i].p));
        end

        // R7: outputs held long after done
        repeat (50) @(negedge clk);
        chk("R7 long hold psc", int'(psc_code), 2);
        chk("R7 long hold scl", int'(scl_code), 1);

        // R8: start while busy is ignored
        cnt0 = done_cnt;
        launch(32'd50, 32'd100000000);   // expect 1,0
        repeat (5) @(negedge clk);
        dly_ns  = 32'd100;
        rate_hz = 32'd1000000000;        // would give 3,3
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        wait_done("R8 busy start");
        chk("R8 psc", int'(psc_code), 1);
        chk("R8 scl", int'(scl_code), 0);
        repeat (300) @(negedge clk);
        chk("R8 single done", done_cnt - cnt0, 1);
        chk("R8 psc after wait", int'(psc_code), 1);

        // R5 again after a saturated result
        launch(32'hFFFFFFFF, 32'hFFFFFFFF);
        wait_done("R6 sat again");
        chk("R6 sat again", int'(sat), 1);
        launch(32'd0, 32'd0);
        wait_done("R5 zero");
        chk("R5 zero psc", int'(psc_code), 0);
        chk("R5 zero scl", int'(scl_code), 0);
        chk("R5 zero sat", int'(sat), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule